// File: doc/BRIEF.md
# Two-Wire Memory Slave Address Front-End

This block is the bus-facing control path of a serial memory that sits on a two-wire (I2C) bus. It runs on a fast system clock and oversamples the clock line and the data line. It finds START and STOP conditions and shifts in the first byte after a START. That byte must carry the fixed type code and a three-bit select code that matches the board strap pins. On a match the block pulls the data line low in the ninth clock. On a mismatch it leaves the line released and goes back to standby until the next START.

After a matched write-type byte, the block takes two more bytes, high-order first, and acknowledges each one. It builds a 14-bit word address from them. It then pulses a strobe for one system clock, presenting the address together with its page number and its byte-in-page offset. After a matched read-type byte, the block does not take any address bytes. It presents the address held from the last completed write, with the same strobe. The open-drain data pin is modelled as an output enable: when it is high, the line is pulled low.

Top module: `eeprom_bus_front`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_oe` and `addr_strobe` are 0. Reset clears the held address to 0.
- R2: A first byte after START whose bits 7:4 are 1010, whose bits 3:1 equal `sel_pins[2:0]` and whose bit 0 is 0 gets an acknowledge. The acknowledge is `sda_oe` high throughout the high phase of the ninth SCL clock.
- R3: If the type code in bits 7:4 is not 1010, the block does not acknowledge that byte. It then acknowledges no further byte until a new START.
- R4: If the select code in bits 3:1 differs from `sel_pins`, the block does not acknowledge the byte.
- R5: After an acknowledged write-type byte, the next two bytes are both acknowledged. The word address becomes {high byte bits 5:0, low byte}, and high byte bits 7:6 are ignored. `addr_strobe` pulses with `rd_flag` = 0 and `mem_addr` set to that address.
- R6: While `addr_strobe` is high, `page_idx` equals `mem_addr[13:5]` and `byte_off` equals `mem_addr[4:0]`.
- R7: An acknowledged first byte with bit 0 = 1 (read) gets `rd_flag` = 1. After its acknowledge clock, `addr_strobe` pulses with `mem_addr` unchanged from the last completed write, or 0 after reset.
- R8: A STOP at any point releases `sda_oe`, abandons the transfer without a strobe and leaves `mem_addr` unchanged.
- R9: A repeated START in the middle of a transfer discards the partial address and restarts reception at the address byte.
- R10: `sda_oe` changes only while SCL is low.
- R11: `addr_strobe` is never high on two consecutive system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND) |
| sel_pins | input | 3 | Strap pins for the device select code |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| addr_strobe | output | 1 | One-clock pulse: address ready for the memory core |
| rd_flag | output | 1 | Operation of the last matched access, 1 = read |
| mem_addr | output | 14 | Word address |
| page_idx | output | 9 | Page number, address bits 13:5 |
| byte_off | output | 5 | Offset within the page, address bits 4:0 |

## Verification
The address match is tested with four kinds of first byte: a full match, a wrong type code, a wrong select code, and a match with the read bit set. These show apart the two reject paths and the read path, in which the held address comes back without any address bytes. The write path is run with all-ones, all-zeros and mixed address patterns. One high byte has bits 7:6 set, which shows whether those bits are masked and whether the page and offset split lands on bit 5. Directed runs cut a transfer with a STOP and with a repeated START, and send a byte with no START at all. These show that a partial address never produces a strobe and that a fresh START is the only way out of standby.

// File: rtl/twfe_pkg.sv
package twfe_pkg;
    localparam int SEL_W  = 3;
    localparam int PAGE_W = 9;
    localparam int OFF_W  = 5;
    localparam int ADDR_W = PAGE_W + OFF_W;
    localparam int HI_W   = ADDR_W - 8;
    localparam logic [3:0] KIND_CODE = 4'b1010;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_ACK  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SL_DEV = 2'd0,
        SL_HI  = 2'd1,
        SL_LO  = 2'd2
    } slot_e;

    typedef struct packed {
        logic [3:0]       kind;
        logic [SEL_W-1:0] sel;
        logic             rd;
    } dev_byte_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } word_addr_t;

    function automatic logic dev_hit(input dev_byte_t b, input logic [SEL_W-1:0] pins);
        return (b.kind == KIND_CODE) && (b.sel == pins);
    endfunction
endpackage

// File: rtl/twfe_line_cond.sv
module twfe_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_hit,
    output logic stop_hit
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // idle bus level is high on both lines
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_raw};
            sda_sh <= {sda_sh[STAGES-2:0], sda_raw};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    // data edges while the clock stays high are bus conditions
    assign start_hit = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_hit  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/twfe_shift.sv
module twfe_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       take,
    input  logic       bit_in,
    output logic [7:0] data,
    output logic [3:0] count
);
    // count 0..8 tracks data bits, 9 marks the acknowledge clock seen
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data  <= '0;
            count <= '0;
        end else if (take) begin
            if (count < 4'd8) begin
                data  <= {data[6:0], bit_in};
                count <= count + 4'd1;
            end else if (count == 4'd8) begin
                count <= 4'd9;
            end
        end
    end
endmodule

// File: rtl/twfe_addr_reg.sv
module twfe_addr_reg
    import twfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [HI_W-1:0]   hi_in,
    input  logic [7:0]        lo_in,
    output logic [ADDR_W-1:0] addr,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  off
);
    logic [HI_W-1:0] hi_q;
    word_addr_t      split;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            addr <= '0;
        end else begin
            if (load_hi) hi_q <= hi_in;
            if (load_lo) addr <= {hi_q, lo_in};
        end
    end

    assign split = word_addr_t'(addr);
    assign page  = split.page;
    assign off   = split.off;
endmodule

// File: rtl/twfe_ctrl.sv
module twfe_ctrl
    import twfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_hit,
    input  logic             stop_hit,
    input  logic             scl_fall,
    input  logic [3:0]       count,
    input  logic [7:0]       data,
    input  logic [SEL_W-1:0] sel_pins,
    output logic             clear,
    output logic             load_hi,
    output logic             load_lo,
    output logic             sda_oe,
    output logic             strobe,
    output logic             rd_flag
);
    phase_e    phase_q, phase_n;
    slot_e     slot_q, slot_n;
    logic      oe_n, rd_n, fire;
    dev_byte_t head;

    assign head = dev_byte_t'(data);

    always_comb begin
        phase_n = phase_q;
        slot_n  = slot_q;
        oe_n    = sda_oe;
        rd_n    = rd_flag;
        clear   = 1'b0;
        load_hi = 1'b0;
        load_lo = 1'b0;
        fire    = 1'b0;
        if (stop_hit) begin
            phase_n = PH_IDLE;
            oe_n    = 1'b0;
        end else if (start_hit) begin
            phase_n = PH_RECV;
            slot_n  = SL_DEV;
            oe_n    = 1'b0;
            clear   = 1'b1;
        end else begin
            unique case (phase_q)
                PH_RECV: begin
                    if (scl_fall && count == 4'd8) begin
                        if (slot_q == SL_DEV) begin
                            if (dev_hit(head, sel_pins)) begin
                                oe_n    = 1'b1;
                                rd_n    = head.rd;
                                phase_n = PH_ACK;
                            end else begin
                                phase_n = PH_IDLE;
                            end
                        end else begin
                            oe_n    = 1'b1;
                            phase_n = PH_ACK;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall && count == 4'd9) begin
                        oe_n  = 1'b0;
                        clear = 1'b1;
                        unique case (slot_q)
                            SL_DEV: begin
                                if (rd_flag) begin
                                    fire    = 1'b1;
                                    phase_n = PH_IDLE;
                                end else begin
                                    slot_n  = SL_HI;
                                    phase_n = PH_RECV;
                                end
                            end
                            SL_HI: begin
                                load_hi = 1'b1;
                                slot_n  = SL_LO;
                                phase_n = PH_RECV;
                            end
                            default: begin
                                load_lo = 1'b1;
                                fire    = 1'b1;
                                phase_n = PH_IDLE;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            slot_q  <= SL_DEV;
            sda_oe  <= 1'b0;
            rd_flag <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            phase_q <= phase_n;
            slot_q  <= slot_n;
            sda_oe  <= oe_n;
            rd_flag <= rd_n;
            strobe  <= fire;
        end
    end
endmodule

// File: rtl/eeprom_bus_front.sv
module eeprom_bus_front
    import twfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [SEL_W-1:0]  sel_pins,
    output logic              sda_oe,
    output logic              addr_strobe,
    output logic              rd_flag,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PAGE_W-1:0] page_idx,
    output logic [OFF_W-1:0]  byte_off
);
    logic       scl_q, sda_q, scl_rise, scl_fall, start_hit, stop_hit;
    logic       clear, load_hi, load_lo;
    logic [7:0] data;
    logic [3:0] count;

    twfe_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_hit(start_hit), .stop_hit(stop_hit)
    );

    twfe_shift u_shift (
        .clk(clk), .rst(rst), .clear(clear), .take(scl_rise), .bit_in(sda_q),
        .data(data), .count(count)
    );

    twfe_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start_hit(start_hit), .stop_hit(stop_hit),
        .scl_fall(scl_fall), .count(count), .data(data), .sel_pins(sel_pins),
        .clear(clear), .load_hi(load_hi), .load_lo(load_lo),
        .sda_oe(sda_oe), .strobe(addr_strobe), .rd_flag(rd_flag)
    );

    twfe_addr_reg u_addr (
        .clk(clk), .rst(rst), .load_hi(load_hi), .load_lo(load_lo),
        .hi_in(data[HI_W-1:0]), .lo_in(data),
        .addr(mem_addr), .page(page_idx), .off(byte_off)
    );
endmodule

// File: rtl/eeprom_bus_front_chk.sv
module eeprom_bus_front_chk (
    input logic clk,
    input logic rst,
    input logic scl_q,
    input logic stop_hit,
    input logic sda_oe,
    input logic addr_strobe
);
    // R1: outputs quiet on the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && !addr_strobe));

    // R10: enable holds steady across a high clock phase
    a_r10_oe_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_q && $past(scl_q)) |-> $stable(sda_oe));

    // R10: enable only rises with the clock line low
    a_r10_oe_rise_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_q);

    // R8: a STOP releases the data line
    a_r8_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_hit |=> !sda_oe);

    // R11: strobe is a single-cycle pulse
    a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> !addr_strobe);
endmodule

bind eeprom_bus_front eeprom_bus_front_chk u_chk (
    .clk(clk), .rst(rst), .scl_q(scl_q), .stop_hit(stop_hit),
    .sda_oe(sda_oe), .addr_strobe(addr_strobe)
);

// File: tb/eeprom_bus_front_test.sv
module eeprom_bus_front_test;
    localparam int Q = 10;
    localparam logic [2:0] PINS = 3'b101;
    localparam int NV = 6;
    // {dev, hi, lo, acks(dev,hi,lo), strobe, addr}
    localparam logic [41:0] VEC [NV] = '{
        {8'hAA, 8'h3F, 8'hFF, 3'b111, 1'b1, 14'h3FFF},
        {8'hAA, 8'hC5, 8'h21, 3'b111, 1'b1, 14'h0521},
        {8'hBA, 8'hAA, 8'h55, 3'b000, 1'b0, 14'h0000},
        {8'hA8, 8'h01, 8'h02, 3'b000, 1'b0, 14'h0000},
        {8'hAA, 8'h00, 8'h00, 3'b111, 1'b1, 14'h0000},
        {8'hAA, 8'h12, 8'hE0, 3'b111, 1'b1, 14'h12E0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_oe, addr_strobe, rd_flag;
    logic [13:0] mem_addr;
    logic [8:0]  page_idx;
    logic [4:0]  byte_off;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int r10_bad = 0;
    int r11_bad = 0;
    logic [13:0] cap_addr;
    logic [8:0]  cap_page;
    logic [4:0]  cap_off;
    logic        cap_rd;
    logic        oe_prev = 1'b0, scl_prev = 1'b1, stb_prev = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    eeprom_bus_front uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sel_pins(PINS),
        .sda_oe(sda_oe), .addr_strobe(addr_strobe), .rd_flag(rd_flag),
        .mem_addr(mem_addr), .page_idx(page_idx), .byte_off(byte_off)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (addr_strobe) begin
                strobes++;
                cap_addr = mem_addr;
                cap_page = page_idx;
                cap_off  = byte_off;
                cap_rd   = rd_flag;
            end
            if (sda_oe !== oe_prev && scl_m && scl_prev) r10_bad++;
            if (addr_strobe && stb_prev) r11_bad++;
        end
        oe_prev  = sda_oe;
        scl_prev = scl_m;
        stb_prev = addr_strobe;
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_cond();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q / 2);
        ack = (sda_bus == 1'b0);
        hold(Q / 2);
        scl_m = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        int base;
        hold(10);
        check("R1 oe in reset", sda_oe, 0);
        check("R1 strobe in reset", addr_strobe, 0);
        rst = 1'b0;
        hold(1);
        check("R1 oe after reset", sda_oe, 0);
        check("R1 addr after reset", mem_addr, 0);
        hold(10);

        // R7: read before any write returns the reset address
        base = strobes;
        start_cond(); send_byte(8'hAB, a0); stop_cond(); hold(20);
        check("R7 read ack", a0, 1);
        check("R7 read strobe", strobes - base, 1);
        check("R7 read flag", cap_rd, 1);
        check("R7 read addr", cap_addr, 14'h0000);

        for (int v = 0; v < NV; v++) begin
            logic [41:0] e;
            e = VEC[v];
            base = strobes;
            start_cond();
            send_byte(e[41:34], a0);
            send_byte(e[33:26], a1);
            send_byte(e[25:18], a2);
            stop_cond(); hold(20);
            check($sformatf("R2/R3/R4 dev ack v%0d", v), a0, e[17]);
            check($sformatf("R5/R3 hi ack v%0d", v), a1, e[16]);
            check($sformatf("R5/R3 lo ack v%0d", v), a2, e[15]);
            check($sformatf("R5 strobes v%0d", v), strobes - base, e[14]);
            if (e[14]) begin
                check($sformatf("R5 addr v%0d", v), cap_addr, e[13:0]);
                check($sformatf("R5 rd_flag v%0d", v), cap_rd, 0);
                check($sformatf("R6 page v%0d", v), cap_page, e[13:5]);
                check($sformatf("R6 offset v%0d", v), cap_off, e[4:0]);
            end
        end

        // R7: read after writes presents the last written address
        base = strobes;
        start_cond(); send_byte(8'hAB, a0); stop_cond(); hold(20);
        check("R7 read strobe 2", strobes - base, 1);
        check("R7 read addr 2", cap_addr, 14'h12E0);
        check("R7 rd flag 2", rd_flag, 1);

        // R8: STOP after the high byte aborts
        base = strobes;
        start_cond(); send_byte(8'hAA, a0); send_byte(8'h05, a1); stop_cond(); hold(20);
        check("R8 hi ack before stop", a1, 1);
        check("R8 no strobe", strobes - base, 0);
        check("R8 addr kept", mem_addr, 14'h12E0);
        check("R8 oe released", sda_oe, 0);
        // R3: standby ignores a matching byte without START
        scl_m = 1'b0; hold(Q);
        send_byte(8'hAA, a0); stop_cond(); hold(20);
        check("R3 no ack without start", a0, 0);

        // R9: repeated START mid-address restarts reception
        base = strobes;
        start_cond(); send_byte(8'hAA, a0); send_byte(8'h11, a1);
        start_cond(); send_byte(8'hAA, a0); send_byte(8'h02, a1); send_byte(8'h34, a2);
        stop_cond(); hold(20);
        check("R9 ack dev after restart", a0, 1);
        check("R9 ack lo after restart", a2, 1);
        check("R9 one strobe", strobes - base, 1);
        check("R9 addr", cap_addr, 14'h0234);

        check("R10 oe changes only with scl low", r10_bad, 0);
        check("R11 strobe single cycle", r11_bad, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule